// File: doc/BRIEF.md
# Address Range Watch Unit

This block sits beside a memory arbiter and observes every access the arbiter grants. It holds a small number of independent watch units (four by default). Each unit is programmed with an inclusive address window, a mask of operation kinds and a mask of client identifiers. An access that falls inside the window, has an enabled operation and comes from an enabled client is a hit.

On the first hit, a unit freezes a record of that access: a one-hot vector of the client, the address, the operation code, the client index and the transfer size. The unit also raises a pending flag. Software reads the record over a simple register port and then clears the two flags on two separate paths. Writing a unit's release register lets the unit capture again. Writing ones to the global acknowledge register clears pending flags. A global mask gates the pending flags onto a single interrupt line.

The observation port is valid/ready. The block never applies back-pressure. `acc_ready` is low while reset is asserted and is high on every cycle after that. An access is taken on a rising clock edge where both `acc_valid` and `acc_ready` are high. A source that keeps `acc_valid` high therefore presents a new access on every cycle. The register port uses a one-cycle write strobe and a combinational read.

Top module: `addr_watch`

## Requirements
- R1: While reset is asserted and right after it, every configuration register reads as zero, as do the interrupt mask, every capture register and every flag. `irq` is low. Because both masks are zero, no access can hit until the unit is programmed.
- R2: `acc_ready` is 0 during reset and 1 on every clock cycle after reset. An access is taken only on a rising edge where `acc_valid` and `acc_ready` are both 1.
- R3: A unit hits only when all of these hold: the first address is at most the access address, the access address is at most the last address (both ends inclusive), bit `acc_op` of the operation mask is 1, and bit `acc_client` of the client mask is 1. A client index of `NUM_CLIENTS` or more never hits. Matching uses the configuration that held before the edge on which the access is taken.
- R4: On a hit while the unit is not holding, the unit captures five values, each readable at its own field: the one-hot client vector (field 4), the address (field 5), the operation code (field 6), the client index (field 7) and the size (field 8). The holding flag (field 9, bit 0) and the pending flag both become 1 after that edge.
- R5: While a unit is holding, further hits change neither its capture registers nor its pending flag.
- R6: Any write to field 9 of a unit clears that unit's holding flag. The captured values stay readable until the next capture, and the pending flag does not change. A hit in the same cycle as the release write counts only if the unit was not holding before that edge.
- R7: Writing global field 2 with bit i set clears the pending flag of unit i. A new capture in the same cycle wins, and the flag stays set.
- R8: Global field 0 is the read/write interrupt mask, one bit per unit. Global field 1 reads the pending flags ANDed with the mask. Global field 3 reads the unmasked pending flags.
- R9: `irq` is the OR of the masked pending flags. It rises after the same edge that takes the hit, or after the edge that writes the mask.
- R10: The register address is {select, field[3:0]}. Select values 0 to `NUM_UNITS`-1 address a unit, and select value `NUM_UNITS` addresses the global set. Per-unit fields 0 to 3 are first address, last address, operation mask and client mask. Reads of unmapped addresses return 0. Writes to read-only fields have no effect.
- R11: The units are independent. A write or a hit that targets one unit leaves every other unit's registers and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Observed access is present |
| acc_ready | output | 1 | High whenever out of reset; never stalls |
| acc_client | input | CID_W | Index of the requesting client |
| acc_addr | input | ADDR_W | Access address |
| acc_op | input | OP_W | Operation code (bit index into the operation mask) |
| acc_size | input | SIZE_W | Transfer size |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address {select, field} |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on reg_addr |
| irq | output | 1 | OR of masked pending flags |

## Verification
The bench uses the default parameters: four units, fourteen clients, four operation kinds, 32-bit addresses and data. With these values the 4-bit client field can carry the indices 14 and 15, which lie outside the mask. This lets the bench reach the never-match case for out-of-range clients. The global select value of 4 also leaves select values 5 to 7 unmapped, so the zero-read rule can be tested. The unit count is small enough that a full read sweep of every register fits between bursts of random traffic.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int FLD_W = 4;

  typedef enum logic [FLD_W-1:0] {
    F_FIRST     = 4'd0,
    F_LAST      = 4'd1,
    F_OPMASK    = 4'd2,
    F_CLMASK    = 4'd3,
    F_CAP_CL    = 4'd4,
    F_CAP_ADDR  = 4'd5,
    F_CAP_OP    = 4'd6,
    F_CAP_FIRST = 4'd7,
    F_CAP_SIZE  = 4'd8,
    F_RELEASE   = 4'd9
  } unit_fld_e;

  typedef enum logic [FLD_W-1:0] {
    G_MASK   = 4'd0,
    G_STATUS = 4'd1,
    G_ACK    = 4'd2,
    G_RAW    = 4'd3
  } glob_fld_e;
endpackage

// File: rtl/mw_match.sv
module mw_match #(
  parameter int ADDR_W      = 32,
  parameter int NUM_CLIENTS = 14,
  parameter int NUM_OPS     = 4,
  parameter int CID_W       = 4,
  parameter int OP_W        = 2
) (
  input  logic [ADDR_W-1:0]      win_lo,
  input  logic [ADDR_W-1:0]      win_hi,
  input  logic [NUM_OPS-1:0]     op_en,
  input  logic [NUM_CLIENTS-1:0] cl_en,
  input  logic [CID_W-1:0]       client,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [OP_W-1:0]        op,
  output logic                   hit
);
  logic in_win, op_ok, cl_ok;

  always_comb begin
    in_win = (addr >= win_lo) && (addr <= win_hi);
    op_ok  = 1'b0;
    cl_ok  = 1'b0;
    for (int k = 0; k < NUM_OPS; k++)
      if (32'(op) == 32'(k)) op_ok = op_en[k];
    for (int k = 0; k < NUM_CLIENTS; k++)
      if (32'(client) == 32'(k)) cl_ok = cl_en[k];
    hit = in_win && op_ok && cl_ok;
  end
endmodule

// File: rtl/mw_unit.sv
module mw_unit
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_CLIENTS = 14,
  parameter int NUM_OPS     = 4,
  parameter int SIZE_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CID_W       = 4,
  parameter int OP_W        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_fire,
  input  logic [CID_W-1:0]  acc_client,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [OP_W-1:0]   acc_op,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              wr_en,
  input  logic [FLD_W-1:0]  fld,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pend_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              pending,
  output logic              holding
);
  logic [ADDR_W-1:0]      lo_q, hi_q, cap_addr_q;
  logic [NUM_OPS-1:0]     opm_q;
  logic [NUM_CLIENTS-1:0] clm_q, cap_cl_q, cl_onehot;
  logic [OP_W-1:0]        cap_op_q;
  logic [CID_W-1:0]       cap_first_q;
  logic [SIZE_W-1:0]      cap_size_q;
  logic                   held_q, pend_q, hit, take;

  mw_match #(
    .ADDR_W(ADDR_W), .NUM_CLIENTS(NUM_CLIENTS), .NUM_OPS(NUM_OPS),
    .CID_W(CID_W), .OP_W(OP_W)
  ) u_match (
    .win_lo(lo_q), .win_hi(hi_q), .op_en(opm_q), .cl_en(clm_q),
    .client(acc_client), .addr(acc_addr), .op(acc_op), .hit(hit)
  );

  always_comb begin
    for (int k = 0; k < NUM_CLIENTS; k++)
      cl_onehot[k] = (32'(acc_client) == 32'(k));
  end

  assign take = acc_fire && hit && !held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q        <= '0;
      hi_q        <= '0;
      opm_q       <= '0;
      clm_q       <= '0;
      cap_cl_q    <= '0;
      cap_addr_q  <= '0;
      cap_op_q    <= '0;
      cap_first_q <= '0;
      cap_size_q  <= '0;
      held_q      <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      if (wr_en) begin
        case (fld)
          F_FIRST:  lo_q  <= wdata[ADDR_W-1:0];
          F_LAST:   hi_q  <= wdata[ADDR_W-1:0];
          F_OPMASK: opm_q <= wdata[NUM_OPS-1:0];
          F_CLMASK: clm_q <= wdata[NUM_CLIENTS-1:0];
          default: ;
        endcase
      end
      if (take) begin
        cap_cl_q    <= cl_onehot;
        cap_addr_q  <= acc_addr;
        cap_op_q    <= acc_op;
        cap_first_q <= acc_client;
        cap_size_q  <= acc_size;
        held_q      <= 1'b1;
        pend_q      <= 1'b1;
      end else begin
        if (wr_en && fld == F_RELEASE) held_q <= 1'b0;
        if (pend_clr) pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (fld)
      F_FIRST:     rdata = DATA_W'(lo_q);
      F_LAST:      rdata = DATA_W'(hi_q);
      F_OPMASK:    rdata = DATA_W'(opm_q);
      F_CLMASK:    rdata = DATA_W'(clm_q);
      F_CAP_CL:    rdata = DATA_W'(cap_cl_q);
      F_CAP_ADDR:  rdata = DATA_W'(cap_addr_q);
      F_CAP_OP:    rdata = DATA_W'(cap_op_q);
      F_CAP_FIRST: rdata = DATA_W'(cap_first_q);
      F_CAP_SIZE:  rdata = DATA_W'(cap_size_q);
      F_RELEASE:   rdata = DATA_W'(held_q);
      default:     rdata = '0;
    endcase
  end

  assign pending = pend_q;
  assign holding = held_q;
endmodule

// File: rtl/addr_watch.sv
module addr_watch
  import mw_pkg::*;
#(
  parameter int NUM_UNITS   = 4,
  parameter int ADDR_W      = 32,
  parameter int NUM_CLIENTS = 14,
  parameter int NUM_OPS     = 4,
  parameter int SIZE_W      = 8,
  parameter int DATA_W      = 32,
  localparam int CID_W  = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1,
  localparam int OP_W   = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1,
  localparam int SEL_W  = $clog2(NUM_UNITS + 1),
  localparam int REG_AW = SEL_W + FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [CID_W-1:0]  acc_client,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [OP_W-1:0]   acc_op,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [SEL_W-1:0]     sel;
  logic [FLD_W-1:0]     fld;
  logic                 ready_q, acc_fire, glob_sel;
  logic [NUM_UNITS-1:0] pend_v, held_v, mask_q, unit_wr, pend_clr;
  logic [DATA_W-1:0]    unit_rdata [NUM_UNITS];

  assign sel      = reg_addr[REG_AW-1:FLD_W];
  assign fld      = reg_addr[FLD_W-1:0];
  assign glob_sel = (32'(sel) == 32'(NUM_UNITS));
  assign acc_fire = acc_valid && ready_q;
  assign acc_ready = ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    assign unit_wr[i]  = reg_wr && (32'(sel) == 32'(i));
    assign pend_clr[i] = reg_wr && glob_sel && (fld == G_ACK) && reg_wdata[i];
    mw_unit #(
      .ADDR_W(ADDR_W), .NUM_CLIENTS(NUM_CLIENTS), .NUM_OPS(NUM_OPS),
      .SIZE_W(SIZE_W), .DATA_W(DATA_W), .CID_W(CID_W), .OP_W(OP_W)
    ) u_unit (
      .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire),
      .acc_client(acc_client), .acc_addr(acc_addr), .acc_op(acc_op),
      .acc_size(acc_size), .wr_en(unit_wr[i]), .fld(fld),
      .wdata(reg_wdata), .pend_clr(pend_clr[i]), .rdata(unit_rdata[i]),
      .pending(pend_v[i]), .holding(held_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (reg_wr && glob_sel && fld == G_MASK) mask_q <= reg_wdata[NUM_UNITS-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (glob_sel) begin
      case (fld)
        G_MASK:   reg_rdata = DATA_W'(mask_q);
        G_STATUS: reg_rdata = DATA_W'(pend_v & mask_q);
        G_RAW:    reg_rdata = DATA_W'(pend_v);
        default:  reg_rdata = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_UNITS; i++)
        if (32'(sel) == 32'(i)) reg_rdata = unit_rdata[i];
    end
  end

  assign irq = |(pend_v & mask_q);
endmodule

// File: rtl/mw_check.sv
module mw_check
  import mw_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 32,
  parameter int REG_AW    = 7,
  localparam int SEL_W    = REG_AW - FLD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              acc_valid,
  input logic              irq,
  input logic [NUM_UNITS-1:0] pend_v,
  input logic [NUM_UNITS-1:0] held_v,
  input logic [NUM_UNITS-1:0] mask_q
);
  logic gack_wr;
  assign gack_wr = reg_wr && (reg_addr == {SEL_W'(NUM_UNITS), G_ACK});

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_chk
    logic rel_wr;
    assign rel_wr = reg_wr && (reg_addr == {SEL_W'(i), F_RELEASE});

    AST_CAPTURE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held_v[i]) |-> pend_v[i]); // R4
    AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      held_v[i] && !rel_wr |=> held_v[i]); // R6
    AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v[i] && !(gack_wr && reg_wdata[i]) |=> pend_v[i]); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      gack_wr && reg_wdata[i] && !acc_valid |=> !pend_v[i]); // R7
  end

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_v != '0)); // R9
  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R8
endmodule

bind addr_watch mw_check #(
  .NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W), .REG_AW(REG_AW)
) u_mw_check (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .acc_valid(acc_valid), .irq(irq),
  .pend_v(pend_v), .held_v(held_v), .mask_q(mask_q)
);

// File: tb/addr_watch_bench.sv
module addr_watch_bench;
  localparam int NU = 4;
  localparam int NC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [3:0]  acc_client = '0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_op = '0;
  logic [7:0]  acc_size = '0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_lo [NU], m_hi [NU], m_caddr [NU];
  logic [3:0]  m_opm [NU];
  logic [13:0] m_clm [NU], m_ccl [NU];
  logic [1:0]  m_cop [NU];
  logic [3:0]  m_cfirst [NU];
  logic [7:0]  m_csize [NU];
  logic [NU-1:0] m_held, m_pend, m_mask;

  always #10 clk = ~clk;

  addr_watch u_addr_watch (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_client(acc_client), .acc_addr(acc_addr), .acc_op(acc_op),
    .acc_size(acc_size), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [6:0] ra(input int s, input int f);
    return {3'(s), 4'(f)};
  endfunction

  function automatic bit m_hit(input int u, input logic [3:0] cl, input logic [31:0] a,
                               input logic [1:0] op);
    if (int'(cl) >= NC) return 0;
    return (a >= m_lo[u]) && (a <= m_hi[u]) && m_opm[u][op] && m_clm[u][cl];
  endfunction

  function automatic logic [31:0] exp_rd(input logic [6:0] a);
    int s = int'(a[6:4]);
    int f = int'(a[3:0]);
    if (s == NU) begin
      case (f)
        0: return 32'(m_mask);
        1: return 32'(m_pend & m_mask);
        3: return 32'(m_pend);
        default: return 0;
      endcase
    end
    if (s > NU) return 0;
    case (f)
      0: return m_lo[s];
      1: return m_hi[s];
      2: return 32'(m_opm[s]);
      3: return 32'(m_clm[s]);
      4: return 32'(m_ccl[s]);
      5: return m_caddr[s];
      6: return 32'(m_cop[s]);
      7: return 32'(m_cfirst[s]);
      8: return 32'(m_csize[s]);
      9: return 32'(m_held[s]);
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input bit w, input logic [6:0] wa, input logic [31:0] wd,
                     input bit v, input logic [3:0] cl, input logic [31:0] ad,
                     input logic [1:0] op, input logic [7:0] sz);
    @(negedge clk);
    reg_wr = w; reg_addr = wa; reg_wdata = wd;
    acc_valid = v; acc_client = cl; acc_addr = ad; acc_op = op; acc_size = sz;
    @(posedge clk);
    #1;
    for (int u = 0; u < NU; u++) begin
      bit take = v && m_hit(u, cl, ad, op) && !m_held[u];
      if (take) begin
        m_ccl[u] = 14'(1) << cl; m_caddr[u] = ad; m_cop[u] = op;
        m_cfirst[u] = cl; m_csize[u] = sz; m_held[u] = 1; m_pend[u] = 1;
      end else begin
        if (w && wa == ra(u, 9)) m_held[u] = 0;
        if (w && wa == ra(NU, 2) && wd[u]) m_pend[u] = 0;
      end
      if (w && wa == ra(u, 0)) m_lo[u] = wd;
      if (w && wa == ra(u, 1)) m_hi[u] = wd;
      if (w && wa == ra(u, 2)) m_opm[u] = wd[3:0];
      if (w && wa == ra(u, 3)) m_clm[u] = wd[13:0];
    end
    if (w && wa == ra(NU, 0)) m_mask = wd[NU-1:0];
    reg_wr = 0; acc_valid = 0;
    chk(irq == |(m_pend & m_mask), "R9 irq", 32'(irq), 32'(|(m_pend & m_mask)));
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic acc(input logic [3:0] cl, input logic [31:0] ad, input logic [1:0] op,
                     input logic [7:0] sz);
    cyc(0, 0, 0, 1, cl, ad, op, sz);
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    reg_addr = a;
    #1;
    e = exp_rd(a);
    chk(reg_rdata == e, tag, reg_rdata, e);
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < NU; s++)
      for (int f = 0; f < 10; f++) rd(ra(s, f), tag);
    rd(ra(NU, 0), "R8 mask"); rd(ra(NU, 1), "R8 status"); rd(ra(NU, 3), "R8 raw");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int u = 0; u < NU; u++) begin
      m_lo[u] = 0; m_hi[u] = 0; m_caddr[u] = 0; m_opm[u] = 0; m_clm[u] = 0;
      m_ccl[u] = 0; m_cop[u] = 0; m_cfirst[u] = 0; m_csize[u] = 0;
    end
    m_held = 0; m_pend = 0; m_mask = 0;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(acc_ready == 0, "R2 ready low in reset", 32'(acc_ready), 0);
    chk(irq == 0, "R1 irq in reset", 32'(irq), 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(acc_ready == 1, "R2 ready after reset", 32'(acc_ready), 1);
    sweep("R1 reset state");
    acc(3, 32'h0, 1, 8'h4);
    rd(ra(0, 9), "R1 zero masks never hit");

    // directed setup: unit0 window 0x100..0x1ff, writes only, client 3
    wr(ra(0, 0), 32'h100); wr(ra(0, 1), 32'h1ff);
    wr(ra(0, 2), 32'b0010); wr(ra(0, 3), 32'h8);
    wr(ra(NU, 0), 32'hf);
    acc(3, 32'h200, 1, 1); rd(ra(0, 9), "R3 one past last");
    acc(3, 32'h0ff, 1, 1); rd(ra(0, 9), "R3 one below first");
    acc(3, 32'h150, 0, 1); rd(ra(0, 9), "R3 op masked");
    acc(4, 32'h150, 1, 1); rd(ra(0, 9), "R3 client masked");
    acc(14, 32'h150, 1, 1); rd(ra(0, 9), "R3 client out of range");
    acc(3, 32'h1ff, 1, 8'h20);
    for (int f = 4; f < 10; f++) rd(ra(0, f), "R4 capture at last addr");
    acc(3, 32'h100, 1, 8'h02);
    rd(ra(0, 5), "R5 later hit ignored"); rd(ra(0, 8), "R5 size kept");
    wr(ra(0, 5), 32'hdead); rd(ra(0, 5), "R10 read-only write ignored");
    wr(ra(0, 9), 0);
    rd(ra(0, 9), "R6 released"); rd(ra(0, 5), "R6 capture kept");
    rd(ra(NU, 3), "R6 pending kept");
    acc(3, 32'h100, 1, 8'h07); rd(ra(0, 5), "R4 capture at first addr");
    wr(ra(NU, 2), 32'h1); rd(ra(NU, 3), "R7 ack clears pending");
    wr(ra(0, 9), 0);
    cyc(1, ra(NU, 2), 32'h1, 1, 3, 32'h180, 1, 8'h9);
    rd(ra(NU, 3), "R7 hit wins over ack");
    wr(ra(NU, 0), 32'h0); rd(ra(NU, 1), "R8 masked status zero");
    rd(ra(NU, 3), "R8 raw pending shown");
    wr(ra(NU, 0), 32'h1);
    rd(ra(5, 0), "R10 unmapped select"); rd(ra(0, 15), "R10 unmapped field");
    // unit1 programmed; unit0 must not change
    wr(ra(1, 0), 32'h1000); wr(ra(1, 1), 32'h1000);
    wr(ra(1, 2), 32'hf); wr(ra(1, 3), 32'h3fff);
    acc(0, 32'h1000, 2, 8'h1);
    sweep("R11 unit independence");

    // constrained random traffic
    for (int u = 0; u < NU; u++) begin
      logic [31:0] b = ($urandom % 32'h1000) << 4;
      wr(ra(u, 0), b); wr(ra(u, 1), b + ($urandom % 64));
      wr(ra(u, 2), $urandom % 16); wr(ra(u, 3), $urandom % 32'h4000);
    end
    wr(ra(NU, 0), $urandom % 16);
    for (int n = 0; n < 600; n++) begin
      int u = int'($urandom % NU);
      int r = int'($urandom % 10);
      logic [31:0] a = m_lo[u] + ($urandom % (m_hi[u] - m_lo[u] + 3)) - 1;
      if (r == 0) cyc(1, ra(u, 9), 0, 1, 4'($urandom), a, 2'($urandom), 8'($urandom));
      else if (r == 1) cyc(1, ra(NU, 2), $urandom % 16, 1, 4'($urandom), a,
                           2'($urandom), 8'($urandom));
      else if (r == 2) cyc(1, ra(NU, 0), $urandom % 16, 0, 0, 0, 0, 0);
      else cyc(0, 0, 0, ($urandom % 4) != 0, 4'($urandom), a, 2'($urandom), 8'($urandom));
      if (n % 100 == 99) sweep("R3 R4 R5 random sweep");
    end
    finish_run();
  end
endmodule